// File: doc/BRIEF.md
# Single-Wire Half-Duplex Serial Port

This block turns one bidirectional pin into an asynchronous serial port that talks in both directions over the same wire, taking turns. Software writes a byte to the data register and the block shifts it out on the pin as a start bit, eight data bits and a stop bit. While sending, it enables the pin driver and ignores the line. When it is not sending, it watches the line, recovers incoming bytes by sampling each bit at its middle, and keeps the last byte in the data register for software to read.

The bit period in system clocks is the divisor. Software can write it through two byte-wide registers. The block can also measure it: once armed, it times the low run of a 0x80 sync character sent by the host. That run is eight bit periods long (start bit plus seven zero data bits), so the measured count is divided by eight and loaded. The whole port does nothing while the debug input is high, because the pin then belongs to the debug function.

Top module: `swire_uart`

## Requirements
- R1: While `dbg_en` is 1, `pin_oe` stays 0, bus writes change nothing (transmit, divisor, arming) and the receiver completes no byte. Reads still return register contents.
- R2: After reset, `tx_empty`=1, `rx_ready`=0, `frame_err`=0, `overrun`=0, `pin_oe`=0, and the divisor reads back as the `RST_DIV` parameter (16).
- R3: A frame is start bit 0, eight data bits LSB first, then stop bit 1. Each bit lasts exactly divisor clocks. `pin_out` is 1 whenever `pin_oe` is 0.
- R4: After a write to address 0, `pin_oe` is 1 for exactly 10×divisor clocks and `tx_empty` is 0 over the same span. A write to address 0 while `tx_empty` is 0 is ignored.
- R5: The start bit appears on the pin in the clock after an accepted write to address 0.
- R6: A write to address 1 sets divisor bits 7:0 and a write to address 2 sets bits 15:8. Both addresses read back those bits.
- R7: Writing address 3 with bit 0 set arms auto-baud. The next low run on the pin, counted in clocks, is divided by 8 (truncated) and loaded as the divisor, and the port then disarms. No byte is received while armed.
- R8: The receiver is blanked while the block drives the pin, so its own transmission never sets `rx_ready`.
- R9: A received byte is readable at address 0 and sets `rx_ready`. `frame_err` is set when the stop bit is sampled low. A read of address 0 clears `rx_ready`, `frame_err` and `overrun`.
- R10: Completing a byte while `rx_ready` is already 1 sets `overrun`, which stays set until address 0 is read. The data register then holds the newer byte.
- R11: A low pulse on an idle line that lasts less than half the divisor is rejected and produces no byte.
- R12: Address 3 reads as status: bit 0 `tx_empty`, bit 1 `rx_ready`, bit 2 `frame_err`, bit 3 `overrun`, bit 4 auto-baud armed, and 0 in bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug function owns the pin; port inactive |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 1 | Level seen on the shared pin |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| tx_empty | output | 1 | Transmitter idle and able to take a byte |
| rx_ready | output | 1 | Unread received byte present |
| frame_err | output | 1 | Last received byte had a low stop bit |
| overrun | output | 1 | A byte arrived before the previous one was read |

## Verification
Transmission is tried with 0xA5 and 0x3C. The two bit mixes show whether bit order and bit length are right, and a second write in the middle of a frame shows whether a busy transmitter is protected. Reception is tried with 0xA5, 0x00 and 0xFF. These tell mid-bit sampling apart from edge sampling, and they confirm that all-zero and all-one data are not mistaken for start or stop bits. A low stop bit, two unread bytes in a row, and a short glitch separate the framing-error, overrun and start-rejection paths from a normal byte. A 0x80 sync at a different bit period, followed by a byte at that rate, shows that the measured divisor is the one actually used.

// File: rtl/swire_uart_pkg.sv
package swire_uart_pkg;
  localparam int unsigned DATA_BITS = 8;
  localparam int unsigned ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] ADR_DATA    = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_BAUD_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_BAUD_HI = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 2'd3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/swire_baud.sv
module swire_baud
  import swire_uart_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned RST_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              line,
  output logic [DIV_W-1:0]  div,
  output logic              armed
);
  localparam int unsigned CNT_W = DIV_W + 3;

  logic [DIV_W-1:0] div_q, div_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             arm_q, arm_n;

  always_comb begin
    div_n = div_q;
    cnt_n = cnt_q;
    arm_n = arm_q;
    if (!en) begin
      arm_n = 1'b0;
    end else if (wr && addr == ADR_BAUD_LO) begin
      div_n[7:0] = wdata;
    end else if (wr && addr == ADR_BAUD_HI) begin
      div_n[DIV_W-1:8] = wdata[DIV_W-9:0];
    end else if (wr && addr == ADR_CTRL && wdata[0]) begin
      arm_n = 1'b1;
      cnt_n = '0;
    end else if (arm_q) begin
      if (!line) begin
        if (cnt_q != {CNT_W{1'b1}}) cnt_n = cnt_q + CNT_W'(1);
      end else if (cnt_q != '0) begin
        div_n = cnt_q[CNT_W-1:3];
        arm_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(RST_DIV);
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else begin
      div_q <= div_n;
      cnt_q <= cnt_n;
      arm_q <= arm_n;
    end
  end

  assign div   = div_q;
  assign armed = arm_q;
endmodule

// File: rtl/swire_tx.sv
module swire_tx
  import swire_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] ld_data,
  input  logic [DIV_W-1:0]     div,
  output logic                 busy,
  output logic                 txd
);
  localparam int unsigned FR_W  = DATA_BITS + 2;
  localparam int unsigned IDX_W = $clog2(FR_W);

  logic             busy_q, busy_n;
  logic [FR_W-1:0]  shf_q, shf_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;

  always_comb begin
    busy_n = busy_q;
    shf_n  = shf_q;
    idx_n  = idx_q;
    cnt_n  = cnt_q;
    if (!en) begin
      busy_n = 1'b0;
    end else if (!busy_q) begin
      if (load) begin
        busy_n = 1'b1;
        shf_n  = {1'b1, ld_data, 1'b0};
        idx_n  = '0;
        cnt_n  = '0;
      end
    end else if (cnt_q == div - DIV_W'(1)) begin
      cnt_n = '0;
      if (idx_q == IDX_W'(FR_W - 1)) begin
        busy_n = 1'b0;
      end else begin
        idx_n = idx_q + IDX_W'(1);
        shf_n = {1'b1, shf_q[FR_W-1:1]};
      end
    end else begin
      cnt_n = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      shf_q  <= '1;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      shf_q  <= shf_n;
      idx_q  <= idx_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? shf_q[0] : 1'b1;
endmodule

// File: rtl/swire_rx.sv
module swire_rx
  import swire_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 line,
  input  logic [DIV_W-1:0]     div,
  input  logic                 rd_clr,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rdy,
  output logic                 ferr,
  output logic                 ovr
);
  localparam int unsigned IDX_W = $clog2(DATA_BITS);

  rx_state_e              st_q, st_n;
  logic [DIV_W-1:0]       cnt_q, cnt_n;
  logic [IDX_W-1:0]       idx_q, idx_n;
  logic [DATA_BITS-1:0]   shf_q, shf_n, dat_q, dat_n;
  logic                   rdy_q, rdy_n, fe_q, fe_n, ov_q, ov_n;
  logic [DIV_W-1:0]       half_m1, full_m1;

  assign half_m1 = (div >> 1) - DIV_W'(1);
  assign full_m1 = div - DIV_W'(1);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    idx_n = idx_q;
    shf_n = shf_q;
    dat_n = dat_q;
    rdy_n = rdy_q;
    fe_n  = fe_q;
    ov_n  = ov_q;
    if (rd_clr) begin
      rdy_n = 1'b0;
      fe_n  = 1'b0;
      ov_n  = 1'b0;
    end
    if (!en) begin
      st_n  = RX_IDLE;
      cnt_n = '0;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (!line) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (cnt_q == half_m1) begin
            cnt_n = '0;
            idx_n = '0;
            st_n  = line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_n = cnt_q + DIV_W'(1);
          end
        end
        RX_DATA: begin
          if (cnt_q == full_m1) begin
            cnt_n = '0;
            shf_n = {line, shf_q[DATA_BITS-1:1]};
            if (idx_q == IDX_W'(DATA_BITS - 1)) st_n = RX_STOP;
            else idx_n = idx_q + IDX_W'(1);
          end else begin
            cnt_n = cnt_q + DIV_W'(1);
          end
        end
        RX_STOP: begin
          if (cnt_q == full_m1) begin
            cnt_n = '0;
            dat_n = shf_q;
            rdy_n = 1'b1;
            fe_n  = ~line;
            ov_n  = ov_n | (rdy_q & ~rd_clr);
            st_n  = line ? RX_IDLE : RX_HOLD;
          end else begin
            cnt_n = cnt_q + DIV_W'(1);
          end
        end
        RX_HOLD: begin
          if (line) st_n = RX_IDLE;
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      shf_q <= '0;
      dat_q <= '0;
      rdy_q <= 1'b0;
      fe_q  <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      idx_q <= idx_n;
      shf_q <= shf_n;
      dat_q <= dat_n;
      rdy_q <= rdy_n;
      fe_q  <= fe_n;
      ov_q  <= ov_n;
    end
  end

  assign rx_data = dat_q;
  assign rdy     = rdy_q;
  assign ferr    = fe_q;
  assign ovr     = ov_q;
endmodule

// File: rtl/swire_uart.sv
module swire_uart
  import swire_uart_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned RST_DIV = 16,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              tx_empty,
  output logic              rx_ready,
  output logic              frame_err,
  output logic              overrun
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [SYNC_N-1:0] pin_sync_q;
  logic              line_s;
  logic              port_en;
  logic              wr_en;
  logic [DIV_W-1:0]  div;
  logic [15:0]       div16;
  logic              ab_armed;
  logic              tx_busy;
  logic              txd;
  logic              rx_en;
  logic              rd_clr;
  logic [DATA_BITS-1:0] rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pin_sync_q <= '1;
    else             pin_sync_q <= {pin_sync_q[SYNC_N-2:0], pin_in};
  end
  assign line_s = pin_sync_q[SYNC_N-1];

  assign port_en = ~dbg_en;
  assign wr_en   = bus_wr & port_en;
  assign rd_clr  = bus_rd & (bus_addr == ADR_DATA);
  assign rx_en   = port_en & ~tx_busy & ~ab_armed;

  swire_baud #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_baud (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (port_en),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .line  (line_s),
    .div   (div),
    .armed (ab_armed)
  );

  swire_tx #(.DIV_W(DIV_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (port_en),
    .load    (wr_en && bus_addr == ADR_DATA),
    .ld_data (bus_wdata),
    .div     (div),
    .busy    (tx_busy),
    .txd     (txd)
  );

  swire_rx #(.DIV_W(DIV_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (rx_en),
    .line    (line_s),
    .div     (div),
    .rd_clr  (rd_clr),
    .rx_data (rx_data),
    .rdy     (rx_ready),
    .ferr    (frame_err),
    .ovr     (overrun)
  );

  assign div16    = 16'(div);
  assign pin_oe   = tx_busy & port_en;
  assign pin_out  = pin_oe ? txd : 1'b1;
  assign tx_empty = ~tx_busy;

  always_comb begin
    case (bus_addr)
      ADR_DATA:    bus_rdata = rx_data;
      ADR_BAUD_LO: bus_rdata = div16[7:0];
      ADR_BAUD_HI: bus_rdata = div16[15:8];
      default:     bus_rdata = {3'b000, ab_armed, overrun, frame_err, rx_ready, tx_empty};
    endcase
  end
endmodule

// File: rtl/swire_uart_chk.sv
module swire_uart_chk (
  input logic       clk,
  input logic       rst_ok_n,
  input logic       dbg_en,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       pin_out,
  input logic       pin_oe,
  input logic       tx_empty,
  input logic       rx_ready,
  input logic       frame_err,
  input logic       overrun
);
  p_quiet_in_debug_r1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    dbg_en |-> !pin_oe);

  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !pin_oe |-> pin_out);

  p_oe_busy_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    pin_oe |-> !tx_empty);

  p_start_bit_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_wr && bus_addr == 2'd0 && tx_empty && !dbg_en) |=> (pin_oe && !pin_out));

  p_no_echo_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $rose(rx_ready) |-> !$past(pin_oe));

  p_ferr_needs_ready_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    frame_err |-> rx_ready);

  p_ovr_needs_ready_r10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    overrun |-> rx_ready);
endmodule

bind swire_uart swire_uart_chk u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_sync_n),
  .dbg_en    (dbg_en),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .tx_empty  (tx_empty),
  .rx_ready  (rx_ready),
  .frame_err (frame_err),
  .overrun   (overrun)
);

// File: tb/swire_uart_tb.sv
`timescale 1ns/1ps
module swire_uart_tb;
  logic       clk;
  logic       rst_n;
  logic       dbg_en;
  logic       bus_wr;
  logic       bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       drv;
  logic       pin_line;
  logic       pin_out, pin_oe, tx_empty, rx_ready, frame_err, overrun;

  int n_chk;
  int n_bad;
  bit done;

  localparam int D = 8;

  assign pin_line = pin_oe ? pin_out : drv;

  swire_uart u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_line), .pin_out(pin_out), .pin_oe(pin_oe),
    .tx_empty(tx_empty), .rx_ready(rx_ready),
    .frame_err(frame_err), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #0.5 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input int p);
    @(negedge clk);
    drv = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv = b[i];
      repeat (p) @(negedge clk);
    end
    drv = stop;
    repeat (p) @(negedge clk);
    drv = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R2 tx_empty", tx_empty, 1);
    chk("R2 rx_ready", rx_ready, 0);
    chk("R2 frame_err", frame_err, 0);
    chk("R2 overrun", overrun, 0);
    chk("R2 pin_oe", pin_oe, 0);
    chk("R3 idle pin_out", pin_out, 1);
    bus_read(2'd1, v); chk("R2 div lo", v, 8'd16);
    bus_read(2'd2, v); chk("R2 div hi", v, 8'd0);
    bus_read(2'd3, v); chk("R12 status at reset", v, 8'h01);
  endtask

  task automatic t_baud_sw();
    logic [7:0] v;
    bus_write(2'd2, 8'h12);
    bus_read(2'd2, v); chk("R6 div hi", v, 8'h12);
    bus_write(2'd2, 8'h00);
    bus_write(2'd1, 8'(D));
    bus_read(2'd1, v); chk("R6 div lo", v, 8'(D));
  endtask

  task automatic t_tx(input logic [7:0] b, input bit poke);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    bus_write(2'd0, b);
    chk("R5 start immediately", {pin_oe, pin_out}, 2'b10);
    chk("R4 tx_empty low", tx_empty, 0);
    if (poke) begin
      bus_write(2'd0, 8'hFF);
      repeat (D/2 - 1) @(negedge clk);
    end else begin
      repeat (D/2) @(negedge clk);
    end
    for (int i = 0; i < 10; i++) begin
      chk($sformatf("R3 bit %0d oe", i), pin_oe, 1);
      chk($sformatf("R3 bit %0d level", i), pin_out, fr[i]);
      if (i < 9) repeat (D) @(negedge clk);
      else repeat (D - D/2) @(negedge clk);
    end
    chk("R4 oe released after 10 bits", pin_oe, 0);
    chk("R4 tx_empty back", tx_empty, 1);
    repeat (4) @(negedge clk);
    chk("R8 no own echo", rx_ready, 0);
  endtask

  task automatic t_rx(input logic [7:0] b);
    logic [7:0] v;
    send_frame(b, 1'b1, D);
    chk("R9 rx_ready", rx_ready, 1);
    chk("R9 frame_err clean", frame_err, 0);
    bus_read(2'd3, v); chk("R12 status ready", v, 8'h03);
    bus_read(2'd0, v); chk($sformatf("R9 data 0x%0h", b), v, {24'd0, b});
    chk("R9 ready cleared by read", rx_ready, 0);
  endtask

  task automatic t_frame_err();
    logic [7:0] v;
    send_frame(8'h0F, 1'b0, D);
    chk("R9 frame_err set", frame_err, 1);
    chk("R9 ready with ferr", rx_ready, 1);
    bus_read(2'd3, v); chk("R12 status ferr", v, 8'h07);
    bus_read(2'd0, v); chk("R9 ferr data", v, 8'h0F);
    chk("R9 ferr cleared", frame_err, 0);
    t_rx(8'h69);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    send_frame(8'h11, 1'b1, D);
    chk("R10 no overrun yet", overrun, 0);
    send_frame(8'h22, 1'b1, D);
    chk("R10 overrun set", overrun, 1);
    bus_read(2'd3, v); chk("R12 status ovr", v, 8'h0B);
    bus_read(2'd0, v); chk("R10 newer byte kept", v, 8'h22);
    chk("R10 overrun cleared", overrun, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    drv = 1'b0;
    repeat (2) @(negedge clk);
    drv = 1'b1;
    repeat (12 * D) @(negedge clk);
    chk("R11 glitch rejected", rx_ready, 0);
  endtask

  task automatic t_autobaud();
    logic [7:0] v;
    bus_write(2'd3, 8'h01);
    bus_read(2'd3, v); chk("R12 armed bit", v, 8'h11);
    @(negedge clk);
    drv = 1'b0;
    repeat (8 * 12) @(negedge clk);
    drv = 1'b1;
    repeat (24) @(negedge clk);
    chk("R7 no byte from sync", rx_ready, 0);
    bus_read(2'd1, v); chk("R7 measured divisor", v, 8'd12);
    bus_read(2'd3, v); chk("R7 disarmed", v, 8'h01);
    send_frame(8'h5A, 1'b1, 12);
    bus_read(2'd0, v); chk("R7 byte at measured rate", v, 8'h5A);
    bus_write(2'd1, 8'(D));
  endtask

  task automatic t_debug();
    logic [7:0] v;
    dbg_en = 1'b1;
    bus_write(2'd0, 8'h55);
    repeat (2) @(negedge clk);
    chk("R1 no drive in debug", pin_oe, 0);
    chk("R1 tx stays empty", tx_empty, 1);
    bus_write(2'd1, 8'd99);
    bus_read(2'd1, v); chk("R1 divisor unchanged", v, 8'(D));
    send_frame(8'h33, 1'b1, D);
    chk("R1 no receive in debug", rx_ready, 0);
    dbg_en = 1'b0;
    repeat (2) @(negedge clk);
    t_rx(8'hC3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; dbg_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = 2'd0; bus_wdata = 8'd0; drv = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_baud_sw();
    t_tx(8'hA5, 1'b0);
    t_tx(8'h3C, 1'b1);
    t_rx(8'hA5);
    t_rx(8'h00);
    t_rx(8'hFF);
    t_frame_err();
    t_overrun();
    t_glitch();
    t_autobaud();
    t_debug();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule